// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

The controller keeps three vector-wide bit arrays for up to 256 interrupt vectors: pending requests, vectors in service, and the trigger mode recorded for each vector. From a task-priority value and the highest vector in service it derives a processor priority. It offers the CPU the highest pending vector whose priority class beats that value. An acknowledge moves the offered vector from pending to in service. An end-of-interrupt strobe retires the highest vector in service and reports whether that vector was level- or edge-triggered, so that an upstream interrupt router can re-arm level sources.

Requests come in on an accept port that carries a vector, a level/edge flag and a unit-enable qualifier. The accept port returns a one-cycle pulse when a request creates a new pending entry. All results are registered. Every stimulus sampled on a clock edge is visible at the outputs straight after that same edge.

Top module: `vec_prio_ctrl`

## Requirements
- R1: While `rst_n` is low, all pending, in-service and trigger bits are cleared and the task priority is 0. `irq_valid`, `irq_vec`, `prio`, `eoi_valid`, `eoi_vec`, `eoi_level` and `acc_taken` all read 0.
- R2: An accept with `unit_en` high and a vector of 16 or more sets that vector's pending bit. `acc_taken` pulses 1 for one cycle only if the bit was clear before.
- R3: Requests for vectors 0 to 15, and any request made while `unit_en` is low, change nothing and give `acc_taken` = 0.
- R4: A level accept (`acc_level` = 1) for a vector that is already pending is discarded and leaves its trigger bit as it was. An edge accept (`acc_level` = 0) for a pending vector clears the trigger bit. Neither gives `acc_taken`.
- R5: A task-priority write keeps only bits 7:0 of `tpr_wdata`.
- R6: The class of a value is its bits 7:4. `prio` equals the task priority when the task-priority class is at least the class of the highest in-service vector. Otherwise `prio` is that class followed by four zero bits. An empty in-service array counts as vector 0.
- R7: `irq_valid` is 1 exactly when a vector is pending and the class of the highest pending vector, with its low four bits zeroed, is strictly greater than `prio`. `irq_vec` then holds that vector; otherwise `irq_vec` is 0.
- R8: An `ack` while `irq_valid` is 1 sets the in-service bit of `irq_vec` and clears its pending bit. An `ack` while `irq_valid` is 0 is ignored.
- R9: An `eoi` clears the highest in-service bit and also clears that vector's trigger bit. `eoi_valid` then pulses for one cycle with `eoi_vec` set to the vector. `eoi_level` is 1 if the trigger bit was set and 0 if it was clear.
- R10: An `eoi` with nothing in service changes no state and gives no `eoi_valid` pulse.
- R11: When strobes coincide, the EOI is applied first, then the acknowledge, then the accept.
- R12: Outputs change only at the clock edge that samples the stimulus, and show its effect right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| unit_en | input | 1 | Controller enable; accepts are dropped while low |
| acc_valid | input | 1 | Accept request strobe |
| acc_vec | input | 8 | Requested vector |
| acc_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| acc_taken | output | 1 | Pulse: the request created a new pending entry |
| tpr_we | input | 1 | Task-priority write strobe |
| tpr_wdata | input | 32 | Task-priority write data (bits 7:0 kept) |
| ack | input | 1 | CPU acknowledge of the offered vector |
| eoi | input | 1 | End-of-interrupt strobe |
| irq_valid | output | 1 | A deliverable vector is offered |
| irq_vec | output | 8 | Offered vector (0 when none) |
| prio | output | 8 | Current processor priority |
| eoi_valid | output | 1 | Pulse: a vector was retired |
| eoi_vec | output | 8 | Retired vector |
| eoi_level | output | 1 | Retired vector was level-triggered |

## Verification
Every result is due one clock edge after the stimulus: the edge that samples an accept, acknowledge, EOI or task-priority write also updates the arrays, the priority, the offered vector and the pulses. The bench applies each stimulus at a falling edge, holds it over exactly one rising edge, and compares at the following falling edge. One directed probe samples just before the capturing edge to show that nothing moves early. The stimulus table chains its steps so that hidden state, such as trigger bits and in-service order, surfaces later through `eoi_level`, `eoi_vec` and `prio`.

// File: rtl/vpc_pkg.sv
package vpc_pkg;

    // Width of a priority class field (upper bits of a vector)
    localparam int CLS_W = 4;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_e;

endpackage

// File: rtl/vpc_msb_find.sv
// Highest-set-bit search over a vector-wide array, organised as words.
module vpc_msb_find #(
    parameter int NUM_VEC = 256,
    parameter int WORD_W  = 32
) (
    input  logic [NUM_VEC-1:0]         bits,
    output logic                       found,
    output logic [$clog2(NUM_VEC)-1:0] idx
);
    localparam int NUM_WORDS = NUM_VEC / WORD_W;
    localparam int LO_W      = $clog2(WORD_W);
    localparam int HI_W      = $clog2(NUM_WORDS);

    logic [NUM_WORDS-1:0]      word_any;
    logic [NUM_WORDS*LO_W-1:0] word_idx;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic [WORD_W-1:0] slice;
        logic [LO_W-1:0]   lidx;

        assign slice = bits[w*WORD_W +: WORD_W];

        always_comb begin
            lidx = '0;
            for (int b = 0; b < WORD_W; b++) begin
                if (slice[b]) lidx = LO_W'(b);
            end
        end

        assign word_any[w]                  = |slice;
        assign word_idx[w*LO_W +: LO_W]     = lidx;
    end

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (word_any[w]) begin
                found = 1'b1;
                idx   = {HI_W'(w), word_idx[w*LO_W +: LO_W]};
            end
        end
    end

endmodule

// File: rtl/vpc_prio_calc.sv
// Processor priority and deliverability from class comparisons.
module vpc_prio_calc
    import vpc_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic [VEC_W-1:0] tpr,
    input  logic             isr_found,
    input  logic [VEC_W-1:0] isr_idx,
    input  logic             irr_found,
    input  logic [VEC_W-1:0] irr_idx,
    output logic [VEC_W-1:0] ppr,
    output logic             deliver
);
    localparam int CLS_LSB = VEC_W - CLS_W;

    logic [VEC_W-1:0] isr_eff;
    logic [VEC_W-1:0] irr_cls;

    always_comb begin
        isr_eff = isr_found ? isr_idx : '0;
        if (tpr[VEC_W-1:CLS_LSB] >= isr_eff[VEC_W-1:CLS_LSB]) begin
            ppr = tpr;
        end else begin
            ppr = {isr_eff[VEC_W-1:CLS_LSB], {CLS_LSB{1'b0}}};
        end
        irr_cls = {irr_idx[VEC_W-1:CLS_LSB], {CLS_LSB{1'b0}}};
        deliver = irr_found && (irr_cls > ppr);
    end

endmodule

// File: rtl/vec_prio_ctrl.sv
module vec_prio_ctrl
    import vpc_pkg::*;
#(
    parameter int NUM_VEC  = 256,
    parameter int WORD_W   = 32,
    parameter int RSVD_VEC = 16,
    parameter int TPR_IN_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       unit_en,
    input  logic                       acc_valid,
    input  logic [$clog2(NUM_VEC)-1:0] acc_vec,
    input  logic                       acc_level,
    output logic                       acc_taken,
    input  logic                       tpr_we,
    input  logic [TPR_IN_W-1:0]        tpr_wdata,
    input  logic                       ack,
    input  logic                       eoi,
    output logic                       irq_valid,
    output logic [$clog2(NUM_VEC)-1:0] irq_vec,
    output logic [$clog2(NUM_VEC)-1:0] prio,
    output logic                       eoi_valid,
    output logic [$clog2(NUM_VEC)-1:0] eoi_vec,
    output logic                       eoi_level
);
    localparam int VEC_W = $clog2(NUM_VEC);

    typedef struct packed {
        logic [NUM_VEC-1:0] irr;
        logic [NUM_VEC-1:0] isr;
        logic [NUM_VEC-1:0] tmr;
        logic [VEC_W-1:0]   tpr;
        logic               eoi_valid;
        logic [VEC_W-1:0]   eoi_vec;
        trig_e              eoi_trig;
        logic               taken;
    } core_t;

    typedef struct packed {
        logic             irq_valid;
        logic [VEC_W-1:0] irq_vec;
        logic [VEC_W-1:0] ppr;
    } pres_t;

    core_t core_d, core_q;
    pres_t pres_d, pres_q;

    logic             isr_cur_found;
    logic [VEC_W-1:0] isr_cur_idx;
    logic             isr_nxt_found;
    logic [VEC_W-1:0] isr_nxt_idx;
    logic             irr_nxt_found;
    logic [VEC_W-1:0] irr_nxt_idx;
    logic [VEC_W-1:0] ppr_nxt;
    logic             deliver_nxt;
    logic             unused_tpr_hi;

    assign unused_tpr_hi = ^tpr_wdata[TPR_IN_W-1:VEC_W];

    // Highest in-service vector of the current state, for EOI
    vpc_msb_find #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_isr_cur (
        .bits  (core_q.isr),
        .found (isr_cur_found),
        .idx   (isr_cur_idx)
    );

    // Next-state array update: EOI, then acknowledge, then accept
    always_comb begin
        core_d           = core_q;
        core_d.eoi_valid = 1'b0;
        core_d.eoi_vec   = '0;
        core_d.eoi_trig  = TRIG_EDGE;
        core_d.taken     = 1'b0;

        if (eoi && isr_cur_found) begin
            core_d.eoi_valid            = 1'b1;
            core_d.eoi_vec              = isr_cur_idx;
            core_d.eoi_trig             = core_q.tmr[isr_cur_idx] ? TRIG_LEVEL : TRIG_EDGE;
            core_d.isr[isr_cur_idx]     = 1'b0;
            core_d.tmr[isr_cur_idx]     = 1'b0;
        end

        if (ack && pres_q.irq_valid) begin
            core_d.isr[pres_q.irq_vec] = 1'b1;
            core_d.irr[pres_q.irq_vec] = 1'b0;
        end

        if (acc_valid && unit_en && (acc_vec >= VEC_W'(RSVD_VEC))) begin
            if (!(core_d.irr[acc_vec] && acc_level)) begin
                core_d.taken        = !core_d.irr[acc_vec];
                core_d.irr[acc_vec] = 1'b1;
                core_d.tmr[acc_vec] = acc_level;
            end
        end

        if (tpr_we) begin
            core_d.tpr = tpr_wdata[VEC_W-1:0];
        end
    end

    vpc_msb_find #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_isr_nxt (
        .bits  (core_d.isr),
        .found (isr_nxt_found),
        .idx   (isr_nxt_idx)
    );

    vpc_msb_find #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_irr_nxt (
        .bits  (core_d.irr),
        .found (irr_nxt_found),
        .idx   (irr_nxt_idx)
    );

    vpc_prio_calc #(.VEC_W(VEC_W)) u_prio (
        .tpr       (core_d.tpr),
        .isr_found (isr_nxt_found),
        .isr_idx   (isr_nxt_idx),
        .irr_found (irr_nxt_found),
        .irr_idx   (irr_nxt_idx),
        .ppr       (ppr_nxt),
        .deliver   (deliver_nxt)
    );

    always_comb begin
        pres_d.ppr       = ppr_nxt;
        pres_d.irq_valid = deliver_nxt;
        pres_d.irq_vec   = deliver_nxt ? irr_nxt_idx : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_q <= '0;
            pres_q <= '0;
        end else begin
            core_q <= core_d;
            pres_q <= pres_d;
        end
    end

    assign acc_taken = core_q.taken;
    assign irq_valid = pres_q.irq_valid;
    assign irq_vec   = pres_q.irq_vec;
    assign prio      = pres_q.ppr;
    assign eoi_valid = core_q.eoi_valid;
    assign eoi_vec   = core_q.eoi_vec;
    assign eoi_level = (core_q.eoi_trig == TRIG_LEVEL);

endmodule

// File: rtl/vpc_checker.sv
module vpc_checker #(
    parameter int VEC_W    = 8,
    parameter int RSVD_VEC = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             unit_en,
    input logic             acc_valid,
    input logic             eoi,
    input logic             acc_taken,
    input logic             irq_valid,
    input logic [VEC_W-1:0] irq_vec,
    input logic [VEC_W-1:0] prio,
    input logic             eoi_valid,
    input logic [VEC_W-1:0] tpr_q
);
    localparam int CLS_LSB = VEC_W - 4;

    assert_offer_beats_prio_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> ({irq_vec[VEC_W-1:CLS_LSB], {CLS_LSB{1'b0}}} > prio));

    assert_offer_not_reserved_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (irq_vec >= VEC_W'(RSVD_VEC)));

    assert_retire_needs_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_valid |-> $past(eoi));

    assert_taken_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_taken |-> $past(acc_valid && unit_en));

    assert_prio_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
        prio[VEC_W-1:CLS_LSB] >= tpr_q[VEC_W-1:CLS_LSB]);

    assert_no_offer_without_vector_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid |-> (irq_vec == '0));

endmodule

bind vec_prio_ctrl vpc_checker #(.VEC_W(VEC_W), .RSVD_VEC(RSVD_VEC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .unit_en   (unit_en),
    .acc_valid (acc_valid),
    .eoi       (eoi),
    .acc_taken (acc_taken),
    .irq_valid (irq_valid),
    .irq_vec   (irq_vec),
    .prio      (prio),
    .eoi_valid (eoi_valid),
    .tpr_q     (core_q.tpr)
);

// File: tb/vec_prio_ctrl_tb.sv
module vec_prio_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        unit_en = 1'b1;
    logic        acc_valid = 1'b0;
    logic [7:0]  acc_vec = '0;
    logic        acc_level = 1'b0;
    logic        acc_taken;
    logic        tpr_we = 1'b0;
    logic [31:0] tpr_wdata = '0;
    logic        ack = 1'b0;
    logic        eoi = 1'b0;
    logic        irq_valid;
    logic [7:0]  irq_vec;
    logic [7:0]  prio;
    logic        eoi_valid;
    logic [7:0]  eoi_vec;
    logic        eoi_level;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    vec_prio_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .unit_en(unit_en),
        .acc_valid(acc_valid), .acc_vec(acc_vec), .acc_level(acc_level),
        .acc_taken(acc_taken), .tpr_we(tpr_we), .tpr_wdata(tpr_wdata),
        .ack(ack), .eoi(eoi), .irq_valid(irq_valid), .irq_vec(irq_vec),
        .prio(prio), .eoi_valid(eoi_valid), .eoi_vec(eoi_vec),
        .eoi_level(eoi_level)
    );

    typedef struct packed {
        logic        tw;
        logic [31:0] tv;
        logic        av;
        logic [7:0]  avec;
        logic        alvl;
        logic        ak;
        logic        eo;
        logic        x_irq;
        logic [7:0]  x_ivec;
        logic [7:0]  x_ppr;
        logic        x_eoi;
        logic [7:0]  x_evec;
        logic        x_elvl;
        logic        x_tk;
        logic [7:0]  tag;
    } step_t;

    localparam int NSTEP = 18;
    // Fields: tw tv av avec alvl ack eoi | irq ivec ppr eoi evec elvl taken | req
    localparam step_t TBL [NSTEP] = '{
        '{0, 32'h0,    1, 8'h35, 0, 0, 0,  1, 8'h35, 8'h00, 0, 8'h00, 0, 1,  8'd2},  // R2 new edge request
        '{0, 32'h0,    1, 8'h35, 0, 0, 0,  1, 8'h35, 8'h00, 0, 8'h00, 0, 0,  8'd4},  // R4 edge repeat
        '{0, 32'h0,    1, 8'h62, 1, 0, 0,  1, 8'h62, 8'h00, 0, 8'h00, 0, 1,  8'd7},  // R7 higher wins
        '{0, 32'h0,    1, 8'h62, 1, 0, 0,  1, 8'h62, 8'h00, 0, 8'h00, 0, 0,  8'd4},  // R4 level repeat dropped
        '{1, 32'h12AB, 0, 8'h00, 0, 0, 0,  0, 8'h00, 8'hAB, 0, 8'h00, 0, 0,  8'd5},  // R5 low byte kept
        '{1, 32'h50,   0, 8'h00, 0, 0, 0,  1, 8'h62, 8'h50, 0, 8'h00, 0, 0,  8'd6},  // R6 tpr class wins
        '{0, 32'h0,    0, 8'h00, 0, 1, 0,  0, 8'h00, 8'h60, 0, 8'h00, 0, 0,  8'd8},  // R8 ack 0x62
        '{0, 32'h0,    1, 8'h7F, 0, 0, 0,  1, 8'h7F, 8'h60, 0, 8'h00, 0, 1,  8'd7},  // R7 above in-service
        '{0, 32'h0,    0, 8'h00, 0, 1, 0,  0, 8'h00, 8'h70, 0, 8'h00, 0, 0,  8'd8},  // R8 ack 0x7F (nested)
        '{0, 32'h0,    0, 8'h00, 0, 0, 1,  0, 8'h00, 8'h60, 1, 8'h7F, 0, 0,  8'd9},  // R9 retire edge 0x7F
        '{0, 32'h0,    0, 8'h00, 0, 0, 1,  0, 8'h00, 8'h50, 1, 8'h62, 1, 0,  8'd9},  // R9 retire level 0x62
        '{0, 32'h0,    0, 8'h00, 0, 0, 1,  0, 8'h00, 8'h50, 0, 8'h00, 0, 0,  8'd10}, // R10 empty eoi
        '{1, 32'h00,   0, 8'h00, 0, 0, 0,  1, 8'h35, 8'h00, 0, 8'h00, 0, 0,  8'd6},  // R6 tpr cleared
        '{0, 32'h0,    1, 8'h0A, 0, 0, 0,  1, 8'h35, 8'h00, 0, 8'h00, 0, 0,  8'd3},  // R3 reserved vector
        '{0, 32'h0,    1, 8'h35, 1, 1, 1,  0, 8'h00, 8'h30, 0, 8'h00, 0, 1,  8'd11}, // R11 eoi,ack,accept
        '{0, 32'h0,    0, 8'h00, 0, 1, 1,  1, 8'h35, 8'h00, 1, 8'h35, 1, 0,  8'd11}, // R11 ack idle ignored
        '{0, 32'h0,    0, 8'h00, 0, 1, 1,  0, 8'h00, 8'h30, 0, 8'h00, 0, 0,  8'd11}, // R11 eoi before ack
        '{0, 32'h0,    0, 8'h00, 0, 0, 1,  0, 8'h00, 8'h00, 1, 8'h35, 0, 0,  8'd9}   // R9 trigger cleared
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        acc_valid = 1'b0; tpr_we = 1'b0; ack = 1'b0; eoi = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        string rq;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1", "irq_valid", 32'(irq_valid), 0);
        chk("R1", "irq_vec",   32'(irq_vec),   0);
        chk("R1", "prio",      32'(prio),      0);
        chk("R1", "eoi_valid", 32'(eoi_valid), 0);
        chk("R1", "acc_taken", 32'(acc_taken), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NSTEP; i++) begin
            tpr_we    = TBL[i].tw;
            tpr_wdata = TBL[i].tv;
            acc_valid = TBL[i].av;
            acc_vec   = TBL[i].avec;
            acc_level = TBL[i].alvl;
            ack       = TBL[i].ak;
            eoi       = TBL[i].eo;
            @(negedge clk);
            idle();
            rq = $sformatf("R%0d step%0d", TBL[i].tag, i);
            chk(rq, "irq_valid", 32'(irq_valid), 32'(TBL[i].x_irq));
            chk(rq, "irq_vec",   32'(irq_vec),   32'(TBL[i].x_ivec));
            chk(rq, "prio",      32'(prio),      32'(TBL[i].x_ppr));
            chk(rq, "eoi_valid", 32'(eoi_valid), 32'(TBL[i].x_eoi));
            chk(rq, "eoi_vec",   32'(eoi_vec),   32'(TBL[i].x_evec));
            chk(rq, "eoi_level", 32'(eoi_level), 32'(TBL[i].x_elvl));
            chk(rq, "acc_taken", 32'(acc_taken), 32'(TBL[i].x_tk));
        end

        // R12: nothing moves before the capturing edge, result right after it
        acc_valid = 1'b1; acc_vec = 8'h90; acc_level = 1'b0;
        #9;
        chk("R12", "irq_valid early", 32'(irq_valid), 0);
        @(negedge clk);
        idle();
        chk("R12", "irq_valid", 32'(irq_valid), 1);
        chk("R12", "irq_vec",   32'(irq_vec),   32'h90);
        chk("R12", "acc_taken", 32'(acc_taken), 1);

        // R3: disabled unit drops a higher request
        unit_en = 1'b0;
        acc_valid = 1'b1; acc_vec = 8'hA5; acc_level = 1'b1;
        @(negedge clk);
        idle();
        unit_en = 1'b1;
        chk("R3", "acc_taken disabled", 32'(acc_taken), 0);
        chk("R3", "irq_vec disabled",   32'(irq_vec),   32'h90);
        @(negedge clk);
        chk("R3", "irq_vec after enable", 32'(irq_vec), 32'h90);

        // R1: reset in mid-run clears pending state
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "irq_valid in reset", 32'(irq_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "irq_valid after reset", 32'(irq_valid), 0);
        chk("R1", "prio after reset",      32'(prio),      0);

        done = 1'b1;
        finish_run();
    end

endmodule